// File: doc/BRIEF.md
# Card Transmit Word Queue with Status Flags

This block holds the words a host writes towards a memory-card data path until the serializer takes them. It stores up to 16 words of 32 bits. The register bus writes words through a window of 16 consecutive word addresses, and every address in that window feeds the same queue. The serializer sees the oldest stored word on a registered output. After it has captured that word into its shift register it pulses a pop, and the next word appears on the output.

The status outputs are full, empty, half-empty, data-available and a sticky underrun flag. The half-empty flag counts free slots, so it can serve directly as a DMA request. An enable input switches the queue on for transmission. While it is low, every flag reads low, the stored words are discarded and bus writes are ignored.

Occupancy is tracked by a state machine with four named states. `Q_OFF` means the queue is disabled. `Q_EMPTY` means it is enabled and holds no word. `Q_PART` means it holds 1 to 15 words. `Q_FULL` means it holds 16 words. The transitions are:

- `go_off`: from any state to `Q_OFF` when the enable is low.
- `wake`: from `Q_OFF` to `Q_EMPTY`, or to `Q_PART` if a push arrives in the same cycle.
- `first_word`: from `Q_EMPTY` to `Q_PART`.
- `last_word`: from `Q_PART` to `Q_EMPTY` when the count reaches 0.
- `top_off`: from `Q_PART` to `Q_FULL` when the count reaches 16.
- `drain`: from `Q_FULL` to `Q_PART` on a pop.
- `hold`: the state stays the same in every other case.

Top module: `txq_buffer`

## Requirements
- R1: The full flag is 1 exactly when the queue is enabled and holds 16 words.
- R2: The empty flag is 1 exactly when the queue is enabled and holds no word.
- R3: The half-empty flag is 1 when the queue is enabled and at least 8 of its 16 slots are free, that is, when it holds 8 words or fewer.
- R4: While the queue is enabled, the data-available flag is always the inverse of the empty flag.
- R5: An underrun occurs when a pop arrives while the queue is enabled and empty and the transmit-active input is 1. An underrun sets a sticky underrun bit, and the underrun flag shows that bit while the queue is enabled. Only the clear strobe resets the bit. If an underrun and a clear arrive in the same cycle, the bit stays set.
- R6: While the enable is low, all five flags read 0, bus writes are ignored, and the stored words are discarded. When the queue is enabled again it starts empty.
- R7: A bus write pushes a word only when bits [7:4] of the word address equal 4'h4, which is the window 8'h40 to 8'h4F. All 16 addresses in the window push into the same queue. A write to any other address has no effect.
- R8: From the cycle after a push or pop, the data output shows the oldest stored word. A pop moves the output on to the next word in write order.
- R9: A bus write to a full queue is dropped. The stored words and the count do not change.
- R10: A push and a pop in the same cycle on a non-empty queue leave the count unchanged.
- R11: A pop on an empty queue does not change the count. It causes an underrun only under the condition in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Enables the queue for transmission |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 8 | Bus word address |
| bus_wdata | input | 32 | Bus write data |
| ser_pop | input | 1 | Serializer has taken the head word |
| ser_active | input | 1 | Serializer is transmitting |
| urun_clr | input | 1 | Strobe that clears the sticky underrun bit |
| ser_data | output | 32 | Registered head word |
| fl_full | output | 1 | Queue holds 16 words |
| fl_empty | output | 1 | Queue holds no word |
| fl_half | output | 1 | At least 8 slots free (DMA request) |
| fl_avail | output | 1 | Queue holds at least one word |
| fl_urun | output | 1 | Sticky underrun bit |

## Verification
The hardest situations to reach are at the edges of occupancy. These are a write to a full queue, a paired push and pop, and an underrun that arrives in the same cycle as its clear. Purely random traffic seldom reaches them. Directed sequences therefore fill the queue to 16 through every window address, force dropped writes, and place the underrun and the clear strobe in one cycle. The random phases change their push and pop weights every 64 cycles, so the count also moves to both ends of its range.

// File: rtl/txq_pkg.sv
package txq_pkg;

    typedef enum logic [1:0] {
        Q_OFF   = 2'd0,
        Q_EMPTY = 2'd1,
        Q_PART  = 2'd2,
        Q_FULL  = 2'd3
    } txq_state_e;

endpackage

// File: rtl/txq_window.sv
module txq_window #(
    parameter int                DEPTH    = 16,
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE = 8'h40
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              wr_hit
);
    localparam int LSB_W = $clog2(DEPTH);

    generate
        if (LSB_W >= ADDR_W) begin : g_all
            // The window covers the whole address space.
            assign wr_hit = bus_wr;
        end else begin : g_dec
            // The low address bits pick a slot in the window and do not matter.
            assign wr_hit = bus_wr &&
                            (bus_addr[ADDR_W-1:LSB_W] == WIN_BASE[ADDR_W-1:LSB_W]);
        end
    endgenerate

endmodule

// File: rtl/txq_ring.sv
module txq_ring #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head_data
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_q, rd_q, rd_nxt;
    logic [DATA_W-1:0] head_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        if (!en)
            rd_nxt = '0;
        else if (pop)
            rd_nxt = bump(rd_q);
        else
            rd_nxt = rd_q;
    end

    always_ff @(posedge clk) begin
        if (push)
            mem[wr_q] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q   <= '0;
            rd_q   <= '0;
            head_q <= '0;
        end else begin
            if (!en) begin
                wr_q <= '0;
                rd_q <= '0;
            end else begin
                if (push) wr_q <= bump(wr_q);
                if (pop)  rd_q <= bump(rd_q);
            end
            // If the new head slot is the one being written now, take the
            // word straight from the bus.
            if (push && (wr_q == rd_nxt))
                head_q <= wdata;
            else
                head_q <= mem[rd_nxt];
        end
    end

    assign head_data = head_q;

    // R6: a disabled queue returns both pointers to the first slot.
    a_r6_ptr_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (wr_q == '0 && rd_q == '0));

    // R10: a paired push and pop moves both pointers by one slot.
    a_r10_pair_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && push && pop) |=> ((wr_q - rd_q) == $past(wr_q - rd_q)));

endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
    import txq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic wr_hit,
    input  logic pop_req,
    input  logic active,
    input  logic clr,
    output logic push_ok,
    output logic pop_ok,
    output logic fl_full,
    output logic fl_empty,
    output logic fl_half,
    output logic fl_avail,
    output logic fl_urun
);
    localparam int CNT_W = $clog2(DEPTH) + 1;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(DEPTH / 2);

    txq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             urun_q, urun_hit, none_held;

    assign none_held = (state_q == Q_OFF) || (state_q == Q_EMPTY);
    assign push_ok   = en && wr_hit && (state_q != Q_FULL);
    assign pop_ok    = en && pop_req && !none_held;
    assign urun_hit  = en && pop_req && active && none_held;

    always_comb begin
        if (!en)
            cnt_d = '0;
        else
            cnt_d = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = Q_OFF;                                  // go_off
        end else begin
            unique case (state_q)
                Q_OFF:   state_d = push_ok ? Q_PART : Q_EMPTY; // wake
                Q_EMPTY: if (push_ok) state_d = Q_PART;        // first_word
                Q_PART: begin
                    if (cnt_d == '0)          state_d = Q_EMPTY; // last_word
                    else if (cnt_d == DEPTH_C) state_d = Q_FULL; // top_off
                end
                Q_FULL:  if (pop_ok) state_d = Q_PART;         // drain
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= Q_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            urun_q <= 1'b0;
        else if (urun_hit)
            urun_q <= 1'b1;
        else if (clr)
            urun_q <= 1'b0;
    end

    // Flag outputs.
    always_comb begin
        fl_full  = 1'b0;
        fl_empty = 1'b0;
        unique case (state_q)
            Q_OFF:   fl_empty = en;
            Q_EMPTY: fl_empty = en;
            Q_PART:  ;
            Q_FULL:  fl_full  = en;
        endcase
        fl_avail = en && !fl_empty;
        fl_half  = en && (cnt_q <= HALF_C);
        fl_urun  = en && urun_q;
    end

    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= DEPTH_C);

    a_r2_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_full && fl_empty));

    a_r5_urun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (urun_q && !clr) |=> urun_q);

    a_r9_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state_q == Q_FULL && wr_hit && !pop_req) |=> (cnt_q == DEPTH_C));

    a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt_q == '0 && pop_req && !wr_hit) |=> (cnt_q == '0));

endmodule

// File: rtl/txq_buffer.sv
module txq_buffer #(
    parameter int                DEPTH    = 16,
    parameter int                DATA_W   = 32,
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              ser_pop,
    input  logic              ser_active,
    input  logic              urun_clr,
    output logic [DATA_W-1:0] ser_data,
    output logic              fl_full,
    output logic              fl_empty,
    output logic              fl_half,
    output logic              fl_avail,
    output logic              fl_urun
);
    logic wr_hit, push_ok, pop_ok;

    txq_window #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_win (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wr_hit   (wr_hit)
    );

    txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (tx_en),
        .wr_hit   (wr_hit),
        .pop_req  (ser_pop),
        .active   (ser_active),
        .clr      (urun_clr),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .fl_full  (fl_full),
        .fl_empty (fl_empty),
        .fl_half  (fl_half),
        .fl_avail (fl_avail),
        .fl_urun  (fl_urun)
    );

    txq_ring #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tx_en),
        .push      (push_ok),
        .pop       (pop_ok),
        .wdata     (bus_wdata),
        .head_data (ser_data)
    );

    // R6: no flag is raised while the queue is disabled.
    a_r6_flags_off: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !(fl_full || fl_empty || fl_half || fl_avail || fl_urun));

    // R4: exactly one of empty and data-available while enabled.
    a_r4_avail_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> $countones({fl_empty, fl_avail}) == 1);

endmodule

// File: tb/txq_buffer_bench.sv
module txq_buffer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0, bus_wr = 1'b0, ser_pop = 1'b0, ser_active = 1'b0, urun_clr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] ser_data;
    logic        fl_full, fl_empty, fl_half, fl_avail, fl_urun;

    int total = 0, fails = 0;
    bit done = 0;
    logic [31:0] mq [$];
    bit mu = 0;

    always #10 clk = ~clk;

    txq_buffer u_txq_buffer (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ser_pop(ser_pop),
        .ser_active(ser_active), .urun_clr(urun_clr), .ser_data(ser_data),
        .fl_full(fl_full), .fl_empty(fl_empty), .fl_half(fl_half),
        .fl_avail(fl_avail), .fl_urun(fl_urun)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit in_win(logic [7:0] a);
        return a[7:4] == 4'h4;
    endfunction

    // Checks every flag and the head word against the model.
    task automatic check_all(string tag);
        int n = mq.size();
        chk({"R1 full ", tag},   fl_full,  tx_en && n == 16);
        chk({"R2 empty ", tag},  fl_empty, tx_en && n == 0);
        chk({"R3 half ", tag},   fl_half,  tx_en && (16 - n) >= 8);
        chk({"R4 avail ", tag},  fl_avail, tx_en && n > 0);
        chk({"R5 urun ", tag},   fl_urun,  tx_en && mu);
        if (!tx_en)
            chk({"R6 flags off ", tag},
                {fl_full, fl_empty, fl_half, fl_avail, fl_urun}, 0);
        if (n > 0)
            chk({"R8 head ", tag}, ser_data, mq[0]);
    endtask

    // Applies one cycle of inputs, updates the model, then checks.
    task automatic step(bit e, bit w, logic [7:0] a, logic [31:0] d,
                        bit p, bit ac, bit c, string tag);
        int n = mq.size();
        tx_en = e; bus_wr = w; bus_addr = a; bus_wdata = d;
        ser_pop = p; ser_active = ac; urun_clr = c;
        if (!e) begin
            mq.delete();
        end else begin
            bit pok = p && n > 0;
            bit wok = w && in_win(a) && n < 16;
            if (pok) void'(mq.pop_front());
            if (wok) mq.push_back(d);
        end
        if (e && p && ac && n == 0) mu = 1;
        else if (c) mu = 0;
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check_all("R6 reset");
        rst_n = 1'b1;
        @(negedge clk);
        step(1, 0, 8'h00, 0, 0, 0, 0, "R2 R3 enable");
        // Fill through every window address (R7), reaching full (R1).
        for (int i = 0; i < 16; i++)
            step(1, 1, 8'h40 + 8'(i), 32'hA000_0000 + 32'(i), 0, 0, 0, "R7 R1 fill");
        step(1, 1, 8'h45, 32'hDEAD_0001, 0, 0, 0, "R9 drop");
        step(1, 1, 8'h4F, 32'hDEAD_0002, 0, 1, 0, "R9 drop");
        for (int i = 0; i < 4; i++)
            step(1, 0, 8'h00, 0, 1, 1, 0, "R8 pop");
        step(1, 1, 8'h50, 32'hBAD0_0050, 0, 0, 0, "R7 outside high");
        step(1, 1, 8'h3F, 32'hBAD0_003F, 0, 0, 0, "R7 outside low");
        for (int i = 0; i < 3; i++)
            step(1, 1, 8'h4A, 32'hB000_0000 + 32'(i), 1, 1, 0, "R10 pair");
        while (mq.size() > 0)
            step(1, 0, 8'h00, 0, 1, 1, 0, "R8 drain");
        step(1, 0, 8'h00, 0, 1, 0, 0, "R11 pop idle");
        step(1, 0, 8'h00, 0, 1, 1, 0, "R5 underrun");
        step(1, 0, 8'h00, 0, 0, 0, 0, "R5 sticky");
        step(1, 0, 8'h00, 0, 1, 1, 1, "R5 set beats clear");
        step(1, 0, 8'h00, 0, 0, 0, 1, "R5 clear");
        step(1, 1, 8'h41, 32'hC0DE_0001, 1, 0, 0, "R11 push on empty");
        step(1, 1, 8'h42, 32'hC0DE_0002, 0, 0, 0, "R8 second");
        step(0, 1, 8'h43, 32'hC0DE_0003, 0, 0, 0, "R6 disable");
        step(0, 0, 8'h00, 0, 1, 1, 0, "R6 pop disabled");
        step(1, 0, 8'h00, 0, 0, 0, 0, "R6 re-enable empty");
        // Random phases with shifting push and pop weights.
        for (int ph = 0; ph < 60; ph++) begin
            int wp = 20 + int'($urandom_range(0, 70));
            int pp = 20 + int'($urandom_range(0, 70));
            for (int k = 0; k < 64; k++) begin
                bit e  = $urandom_range(0, 99) < 97;
                bit w  = $urandom_range(0, 99) < wp;
                bit p  = $urandom_range(0, 99) < pp;
                bit ac = $urandom_range(0, 99) < 70;
                bit c  = $urandom_range(0, 99) < 6;
                logic [7:0] a = ($urandom_range(0, 99) < 88) ?
                                8'h40 + 8'($urandom_range(0, 15)) : 8'($urandom);
                step(e, w, a, $urandom, p, ac, c, "random");
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule